// File: doc/BRIEF.md
# Trip Relay Drive Stage with Supply and Alarm Blocking

This block takes the qualified, held trip request of a line-protection logic unit and turns it into the signals that energise the trip relays. One output is a steady level for an electromechanical relay. The other is a square wave at half duty for a solid-state relay: the system clock is divided down to about 32 kHz. A front-panel trip indicator follows the drive. As a configuration option it stays lit after the trip has gone, until an operator reset clears it.

Two supervision conditions suppress both drives. The first is an active alarm. The second is loss of supply: power is taken as good while at least one of the two supply-supervision inputs is high. After power returns, the drives stay blocked for a further hold-off counted in millisecond ticks, 600 by default. The same hold-off applies after reset, which the block treats as a power-up. The electromechanical drive is registered, so the block adds one clock of latency from its inputs to that output.

Top module: `trip_drive`

## Requirements
- R1: `relay_em` is high in a cycle exactly when, at the previous rising clock edge, `trip_held` was high, `alarm` was low and no power blocking was in force.
- R2: `relay_ss` is low in every cycle where `relay_em` is low.
- R3: Counting from the first cycle `relay_em` is high as cycle 0, `relay_ss` in cycle k equals bit 0 of k / HALF_DIV. The default HALF_DIV is 1953 at 125 MHz, which gives about 32 kHz. Each new rise of `relay_em` restarts the pattern low.
- R4: While `alarm` is high both drives are low. When `alarm` falls with `trip_held` still high, `relay_em` returns one cycle later.
- R5: Power counts as good when `pgood_a` OR `pgood_b` is high. One input low on its own does not block the drives; both low blocks them from the next cycle.
- R6: After power becomes good again, the drives stay blocked until HOLDOFF_MS pulses of `ms_tick` have been seen while power is good. If power is lost during this count, the count restarts in full.
- R7: After reset is released, the drives stay blocked until HOLDOFF_MS `ms_tick` pulses have been seen.
- R8: With `latch_en` low, `trip_ind` equals `relay_em` in every cycle.
- R9: With `latch_en` high, `trip_ind` stays high after `relay_em` falls. It clears one cycle after `ind_reset` is sampled high while `relay_em` is low. `ind_reset` has no effect while `relay_em` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| trip_held | input | 1 | Held trip request |
| alarm | input | 1 | Abnormal-condition alarm, high blocks trips |
| pgood_a | input | 1 | First supply-supervision input, high when supply is good |
| pgood_b | input | 1 | Second supply-supervision input, high when supply is good |
| latch_en | input | 1 | Configuration: latch the trip indicator |
| ind_reset | input | 1 | Indicator reset request |
| relay_em | output | 1 | Electromechanical relay drive level |
| relay_ss | output | 1 | Solid-state relay drive square wave |
| trip_ind | output | 1 | Trip indicator |

## Verification
A wrong hold-off count shows up at `relay_em` as a trip released one millisecond tick too early or too late. The bench finds it on the first trip after recovery. A divider that is off by one moves the first rising edge of `relay_ss` by a cycle, which shows within 2*HALF_DIV cycles of the drive starting. A phase register that is not cleared between trips shows as a high `relay_ss` in cycle 0 of the next trip. A stuck latch shows as `trip_ind` failing to clear one cycle after a valid reset, or clearing while the drive is still active.

// File: rtl/trip_drive_pkg.sv
package trip_drive_pkg;

  // Next value of the power hold-off counter.
  // Power lost: reload the full hold-off. Power good: one step down per ms tick.
  function automatic int unsigned holdoff_next(input int unsigned cur,
                                               input logic power_ok,
                                               input logic tick,
                                               input int unsigned full);
    if (!power_ok)
      return full;
    else if (tick && cur != 0)
      return cur - 1;
    else
      return cur;
  endfunction

  // True on the last cycle of a half period of the solid-state wave.
  function automatic logic half_period_end(input int unsigned cnt,
                                           input int unsigned half);
    return cnt == half - 1;
  endfunction

  // Next value of the divider counter.
  function automatic int unsigned div_next(input int unsigned cnt,
                                           input int unsigned half);
    if (half_period_end(cnt, half))
      return 0;
    else
      return cnt + 1;
  endfunction

endpackage

// File: rtl/trip_power_guard.sv
module trip_power_guard
  import trip_drive_pkg::*;
#(
  parameter int unsigned HOLDOFF_MS = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pgood_a,
  input  logic pgood_b,
  output logic power_good,
  output logic pwr_block
);

  localparam int unsigned CW = (HOLDOFF_MS > 0) ? $clog2(HOLDOFF_MS + 1) : 1;

  logic [CW-1:0] hold_q;

  assign power_good = pgood_a | pgood_b;

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_q <= CW'(HOLDOFF_MS);
    else
      hold_q <= CW'(holdoff_next(32'(hold_q), power_good, ms_tick, HOLDOFF_MS));
  end

  assign pwr_block = !power_good || (hold_q != '0);

  // R5 / R6: a power loss keeps blocking into the next cycle
  a_r6_loss_blocks_next: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> pwr_block);

  // R6: the counter only moves on a tick while power is good
  a_r6_count_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (power_good && !ms_tick) |=> $stable(hold_q));

  // R6: power returning never releases the block at once
  a_r6_rise_still_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_good) |-> pwr_block);

endmodule

// File: rtl/trip_ss_wave.sv
module trip_ss_wave
  import trip_drive_pkg::*;
#(
  parameter int unsigned HALF_DIV = 1953
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic wave,
  output logic wrap
);

  localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_q;
  logic          phase_q;

  assign wrap = enable && half_period_end(32'(div_q), HALF_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (!enable) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      div_q <= DW'(div_next(32'(div_q), HALF_DIV));
      if (wrap)
        phase_q <= ~phase_q;
    end
  end

  assign wave = phase_q & enable;

  // R3: every new burst starts low
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !phase_q);

  // R3: the phase changes within a burst only after a half-period end
  a_r3_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (phase_q != $past(phase_q))) |-> $past(wrap));

endmodule

// File: rtl/trip_indicator.sv
module trip_indicator (
  input  logic clk,
  input  logic rst_n,
  input  logic drive,
  input  logic latch_en,
  input  logic ind_reset,
  output logic ind
);

  logic latched_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      latched_q <= 1'b0;
    else if (drive && latch_en)
      latched_q <= 1'b1;
    else if (ind_reset && !drive)
      latched_q <= 1'b0;
    else if (!latch_en)
      latched_q <= 1'b0;
  end

  assign ind = latch_en ? (latched_q | drive) : drive;

  // R9: a lit, latched indicator stays lit without a reset
  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ind && latch_en && !ind_reset) |=> (ind || !latch_en));

  // R9: a reset taken with the drive idle clears the indicator
  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ind_reset) && !$past(drive) && !drive && latch_en) |-> !ind);

endmodule

// File: rtl/trip_drive.sv
module trip_drive #(
  parameter int unsigned HALF_DIV   = 1953,
  parameter int unsigned HOLDOFF_MS = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic trip_held,
  input  logic alarm,
  input  logic pgood_a,
  input  logic pgood_b,
  input  logic latch_en,
  input  logic ind_reset,
  output logic relay_em,
  output logic relay_ss,
  output logic trip_ind
);

  logic power_good;
  logic pwr_block;
  logic drive_ok;
  logic relay_em_q;
  logic ss_wrap;

  trip_power_guard #(.HOLDOFF_MS(HOLDOFF_MS)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .pgood_a    (pgood_a),
    .pgood_b    (pgood_b),
    .power_good (power_good),
    .pwr_block  (pwr_block)
  );

  assign drive_ok = trip_held && !alarm && !pwr_block;

  always_ff @(posedge clk) begin
    if (!rst_n)
      relay_em_q <= 1'b0;
    else
      relay_em_q <= drive_ok;
  end

  assign relay_em = relay_em_q;

  trip_ss_wave #(.HALF_DIV(HALF_DIV)) u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (relay_em_q),
    .wave   (relay_ss),
    .wrap   (ss_wrap)
  );

  trip_indicator u_ind (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive     (relay_em_q),
    .latch_en  (latch_en),
    .ind_reset (ind_reset),
    .ind       (trip_ind)
  );

  // R1: no drive without a trip request one cycle before
  a_r1_em_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    relay_em |-> $past(trip_held));

  // R4: an alarm suppresses the drive on the following cycle
  a_r4_alarm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !relay_em);

  // R5: both supplies low suppress the drive on the following cycle
  a_r5_pwr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |=> !relay_em);

  // R2: the solid-state wave exists only under an active drive
  a_r2_ss_gated: assert property (@(posedge clk) disable iff (!rst_n)
    relay_ss |-> relay_em);

  // R3: the wave never turns over in the same cycle the drive starts
  a_r3_no_wrap_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relay_em) |-> !ss_wrap || (HALF_DIV == 1));

endmodule

// File: tb/trip_drive_bench.sv
module trip_drive_bench;

  localparam int unsigned HALF = 4;
  localparam int unsigned HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, trip_held = 1'b0, alarm = 1'b0;
  logic pgood_a = 1'b1, pgood_b = 1'b1, latch_en = 1'b0, ind_reset = 1'b0;
  logic relay_em, relay_ss, trip_ind;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  trip_drive #(.HALF_DIV(HALF), .HOLDOFF_MS(HOLD)) u_trip_drive (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .trip_held(trip_held),
    .alarm(alarm), .pgood_a(pgood_a), .pgood_b(pgood_b), .latch_en(latch_en),
    .ind_reset(ind_reset), .relay_em(relay_em), .relay_ss(relay_ss),
    .trip_ind(trip_ind)
  );

  // {trip, alarm, pgood_a, pgood_b, expected relay_em}
  localparam logic [4:0] VEC [8] = '{
    5'b1_0_1_1_1,   // R1 trip passes
    5'b0_0_1_1_0,   // R1 no trip
    5'b1_1_1_1_0,   // R4 alarm blocks
    5'b1_0_1_1_1,   // R4 alarm dropped, drive back
    5'b1_0_0_1_1,   // R5 only A low
    5'b1_0_1_0_1,   // R5 only B low
    5'b0_1_0_1_0,   // R4 alarm, no trip
    5'b1_0_0_0_0    // R5 both low block
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_ms();
    ms_tick = 1'b1;
    step(1);
    ms_tick = 1'b0;
    step(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    step(3);
    check("R1 reset em", relay_em, 1'b0);
    check("R2 reset ss", relay_ss, 1'b0);
    check("R8 reset ind", trip_ind, 1'b0);
    rst_n = 1'b1;

    // R7: power-up hold-off
    trip_held = 1'b1;
    step(2);
    check("R7 blocked after reset", relay_em, 1'b0);
    for (int i = 0; i < int'(HOLD) - 1; i++) tick_ms();
    step(1);
    check("R7 blocked one tick short", relay_em, 1'b0);
    tick_ms();
    check("R7 released after full hold-off", relay_em, 1'b1);

    // Table walk: R1, R4, R5
    for (int v = 0; v < 8; v++) begin
      trip_held = VEC[v][4];
      alarm     = VEC[v][3];
      pgood_a   = VEC[v][2];
      pgood_b   = VEC[v][1];
      step(1);
      check($sformatf("R1/R4/R5 vector %0d em", v), relay_em, VEC[v][0]);
      if (!VEC[v][0]) check($sformatf("R2 vector %0d ss", v), relay_ss, 1'b0);
    end

    // R6: recovery hold-off and restart
    pgood_a = 1'b1;
    pgood_b = 1'b1;
    step(1);
    check("R6 blocked at recovery", relay_em, 1'b0);
    tick_ms();
    tick_ms();
    check("R6 blocked after two ticks", relay_em, 1'b0);
    pgood_a = 1'b0;
    pgood_b = 1'b0;
    step(1);
    pgood_a = 1'b1;
    step(1);
    tick_ms();
    tick_ms();
    check("R6 restart keeps block", relay_em, 1'b0);
    tick_ms();
    check("R6 released after full count", relay_em, 1'b1);

    // R3: waveform from a fresh trip
    trip_held = 1'b0;
    step(2);
    check("R2 ss low when idle", relay_ss, 1'b0);
    trip_held = 1'b1;
    step(1);
    for (int k = 0; k < 12; k++) begin
      check($sformatf("R3 cycle %0d", k), relay_ss, 1'((k / int'(HALF)) % 2));
      step(1);
    end
    // R3 restart low at a new trip mid-pattern
    trip_held = 1'b0;
    step(1);
    check("R2 ss low when drive drops", relay_ss, 1'b0);
    trip_held = 1'b1;
    step(1);
    for (int k = 0; k < int'(HALF) + 1; k++) begin
      check($sformatf("R3 restart cycle %0d", k), relay_ss, 1'((k / int'(HALF)) % 2));
      step(1);
    end

    // R8: indicator follows without latching
    latch_en = 1'b0;
    check("R8 ind follows on", trip_ind, relay_em);
    trip_held = 1'b0;
    step(1);
    check("R8 ind follows off", trip_ind, 1'b0);

    // R9: latched indicator
    latch_en = 1'b1;
    trip_held = 1'b1;
    step(1);
    check("R9 ind on", trip_ind, 1'b1);
    ind_reset = 1'b1;
    step(1);
    ind_reset = 1'b0;
    trip_held = 1'b0;
    step(2);
    check("R9 relay off", relay_em, 1'b0);
    check("R9 reset during trip ignored", trip_ind, 1'b1);
    step(3);
    check("R9 ind stays latched", trip_ind, 1'b1);
    ind_reset = 1'b1;
    step(1);
    ind_reset = 1'b0;
    check("R9 reset clears", trip_ind, 1'b0);

    finish_run();
  end

endmodule